// File: doc/BRIEF.md
# Prescaled 8-bit Overflow Timer

This block is an 8-bit up-counter driven by a selectable prescaler. A three-bit clock-select field chooses whether the counter stops, advances on every system clock, or advances once every 8, 64, 256 or 1024 clocks. The prescale taps come from one free-running 10-bit divider that is cleared by reset. A tick fires on the clock edge at which the divider's low bits for the selected ratio are all ones. When a tick finds the counter at 0xFF, the counter wraps to 0x00 and raises a sticky overflow flag.

A CPU reaches the timer through a small register port. Writes take effect on the clock edge at which `bus_we` is high. Reads are combinational from `bus_addr`. The overflow flag, a local overflow enable and the CPU's global interrupt enable together form an interrupt request. The interrupt controller accepts the request by raising `irq_ack`. Acceptance clears the flag in hardware. After a fixed entry latency of two cycles, the block presents the handler address 0x20 for one cycle.

Top module: `ovf_timer`

## Requirements
- R1: With clock-select 1 the counter advances by one on every clock edge. A write of the clock-select field takes effect from the edge after the write edge.
- R2: Clock-select 2, 3, 4 and 5 divide by 8, 64, 256 and 1024. The divider is cleared by reset and counts every edge. A tick occurs on edge n (counted from 0 after reset) exactly when n mod ratio equals ratio-1. With select 3 set on edge 0, the counter therefore first reads 1 after 64 edges.
- R3: Clock-select 0, 6 and 7 stop the counter, and its value holds for any number of clocks.
- R4: A tick at counter value 0xFF wraps the counter to 0x00 and sets the overflow flag, which reads as bit 0 at address 0x35.
- R5: `irq_req` is high only while the overflow flag, the enable bit (bit 0 at address 0x6E) and `glob_ie` are all set. Otherwise the flag stays set, and a pulse on `irq_ack` has no effect.
- R6: An `irq_ack` sampled while `irq_req` is high clears the overflow flag on that edge.
- R7: After acceptance, `vec_valid` is low in the first following cycle and high in the second, with `vec_addr` = 0x20. It is low again afterwards. `irq_req` stays low while entry is in progress.
- R8: The control register is at address 0x45 and keeps only its low 3 bits as the clock-select field; its other bits read 0. The counter is at 0x46 for read and write. The enable register keeps bit 0 only. Unmapped addresses read 0.
- R9: Writing 1 to bit 0 at 0x35 clears the overflow flag, and writing 0 leaves it unchanged. An overflow on the same edge as a clearing write leaves the flag set.
- R10: A write to the counter on an edge that also carries a tick loads the written value, not the increment, and raises no overflow on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register address |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| glob_ie | input | 1 | Global interrupt enable from the CPU |
| irq_req | output | 1 | Overflow interrupt request |
| irq_ack | input | 1 | Interrupt accepted by the controller |
| vec_valid | output | 1 | Handler address valid at the end of entry |
| vec_addr | output | 16 | Handler address (0x20) |

## Verification
On every cycle the assertions check the following: the single-step and hold behaviour for clock-selects 1, 0, 6 and 7; the wrap-and-flag rule; the three-way gating of the request; flag clearing on acceptance; the vector value and the quiet request during entry; and write priority over an increment. Division ratios and the phase of the first tick after reset depend on many cycles of divider history, so only the bench's scenarios can show them. The same holds for the exact entry latency and for an overflow coinciding with a software clear. The bench checks these against a closed-form tick count.

// File: rtl/ovf_timer_pkg.sv
package ovf_timer_pkg;

   localparam int unsigned CS_W      = 3;
   localparam int unsigned MAX_SHIFT = 10;

   localparam logic [7:0] REG_CTRL = 8'h45;
   localparam logic [7:0] REG_CNT  = 8'h46;
   localparam logic [7:0] REG_FLAG = 8'h35;
   localparam logic [7:0] REG_MASK = 8'h6E;

   typedef enum logic [CS_W-1:0] {
      SEL_STOP   = 3'd0,
      SEL_D1     = 3'd1,
      SEL_D8     = 3'd2,
      SEL_D64    = 3'd3,
      SEL_D256   = 3'd4,
      SEL_D1024  = 3'd5,
      SEL_IDLE_A = 3'd6,
      SEL_IDLE_B = 3'd7
   } clk_sel_e;

   // log2 of the prescale ratio for a select code, -1 when the code stops the counter
   function automatic int sel_shift(input int code);
      case (code)
         int'(SEL_D1):    return 0;
         int'(SEL_D8):    return 3;
         int'(SEL_D64):   return 6;
         int'(SEL_D256):  return 8;
         int'(SEL_D1024): return 10;
         default:         return -1;
      endcase
   endfunction

endpackage

// File: rtl/ovf_timer_prescale.sv
module ovf_timer_prescale
   import ovf_timer_pkg::*;
#(
   parameter int unsigned DIV_W = 10
)(
   input  logic            clk,
   input  logic            rst_n,
   input  logic [CS_W-1:0] cs,
   output logic            tick
);

   localparam int unsigned N_CODES = 1 << CS_W;

   logic [DIV_W-1:0]   div_q;
   logic [N_CODES-1:0] tick_by_code;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) div_q <= '0;
      else        div_q <= div_q + 1'b1;
   end

   for (genvar g = 0; g < N_CODES; g++) begin : g_code
      localparam int SH = sel_shift(g);
      if (SH < 0) begin : g_stop
         assign tick_by_code[g] = 1'b0;
      end else if (SH == 0) begin : g_every
         assign tick_by_code[g] = 1'b1;
      end else begin : g_div
         assign tick_by_code[g] = &div_q[SH-1:0];
      end
   end

   assign tick = tick_by_code[cs];

endmodule

// File: rtl/ovf_timer_regs.sv
module ovf_timer_regs
   import ovf_timer_pkg::*;
#(
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned DATA_W = 8,
   parameter int unsigned CNT_W  = 8
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [CNT_W-1:0]  cnt_val,
   input  logic              flag_val,
   output logic [CS_W-1:0]   cs,
   output logic              ovf_ie,
   output logic              cnt_wr,
   output logic [CNT_W-1:0]  cnt_wdata,
   output logic              flag_wr_clr
);

   logic hit_ctrl, hit_cnt, hit_flag, hit_mask;
   logic [CS_W-1:0] cs_q;
   logic            ie_q;

   assign hit_ctrl = (bus_addr == ADDR_W'(REG_CTRL));
   assign hit_cnt  = (bus_addr == ADDR_W'(REG_CNT));
   assign hit_flag = (bus_addr == ADDR_W'(REG_FLAG));
   assign hit_mask = (bus_addr == ADDR_W'(REG_MASK));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_q <= '0;
         ie_q <= 1'b0;
      end else if (bus_we) begin
         if (hit_ctrl) cs_q <= bus_wdata[CS_W-1:0];
         if (hit_mask) ie_q <= bus_wdata[0];
      end
   end

   assign cs          = cs_q;
   assign ovf_ie      = ie_q;
   assign cnt_wr      = bus_we & hit_cnt;
   assign cnt_wdata   = bus_wdata[CNT_W-1:0];
   assign flag_wr_clr = bus_we & hit_flag & bus_wdata[0];

   always_comb begin
      bus_rdata = '0;
      if (hit_ctrl)      bus_rdata[CS_W-1:0]  = cs_q;
      else if (hit_cnt)  bus_rdata[CNT_W-1:0] = cnt_val;
      else if (hit_flag) bus_rdata[0]         = flag_val;
      else if (hit_mask) bus_rdata[0]         = ie_q;
   end

endmodule

// File: rtl/ovf_timer_count.sv
module ovf_timer_count #(
   parameter int unsigned CNT_W = 8
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             cnt_wr,
   input  logic [CNT_W-1:0] cnt_wdata,
   output logic [CNT_W-1:0] cnt_q,
   output logic             ovf_evt
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (cnt_wr) cnt_q <= cnt_wdata;
      else if (tick)   cnt_q <= cnt_q + 1'b1;
   end

   assign ovf_evt = tick & ~cnt_wr & (&cnt_q);

endmodule

// File: rtl/ovf_timer_irq.sv
module ovf_timer_irq #(
   parameter int unsigned ENTRY_CYCLES = 2,
   parameter int unsigned VEC_W        = 16,
   parameter int unsigned VEC_ADDR     = 32'h20
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ovf_evt,
   input  logic             sw_clr,
   input  logic             ovf_ie,
   input  logic             glob_ie,
   input  logic             irq_ack,
   output logic             flag_q,
   output logic             irq_req,
   output logic             vec_valid,
   output logic [VEC_W-1:0] vec_addr
);

   logic accept;
   logic entering;

   assign irq_req  = flag_q & ovf_ie & glob_ie & ~entering;
   assign accept   = irq_req & irq_ack;
   assign vec_addr = VEC_W'(VEC_ADDR);

   // a hardware overflow outranks any clear arriving on the same edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                flag_q <= 1'b0;
      else if (ovf_evt)          flag_q <= 1'b1;
      else if (accept || sw_clr) flag_q <= 1'b0;
   end

   if (ENTRY_CYCLES == 0) begin : g_immediate
      assign entering  = 1'b0;
      assign vec_valid = accept;
   end else begin : g_delayed
      localparam int unsigned ENT_W = $clog2(ENTRY_CYCLES + 1);
      logic [ENT_W-1:0] ent_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        ent_q <= '0;
         else if (accept)   ent_q <= ENT_W'(ENTRY_CYCLES);
         else if (entering) ent_q <= ent_q - 1'b1;
      end
      assign entering  = (ent_q != '0);
      assign vec_valid = (ent_q == ENT_W'(1));
   end

endmodule

// File: rtl/ovf_timer.sv
module ovf_timer
   import ovf_timer_pkg::*;
#(
   parameter int unsigned ADDR_W       = 8,
   parameter int unsigned DATA_W       = 8,
   parameter int unsigned CNT_W        = 8,
   parameter int unsigned DIV_W        = 10,
   parameter int unsigned ENTRY_CYCLES = 2,
   parameter int unsigned VEC_W        = 16,
   parameter int unsigned VEC_ADDR     = 32'h20
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              glob_ie,
   output logic              irq_req,
   input  logic              irq_ack,
   output logic              vec_valid,
   output logic [VEC_W-1:0]  vec_addr
);

   if (CNT_W > DATA_W) begin : g_bad_cnt
      $error("counter wider than the data bus");
   end
   if (DATA_W < CS_W) begin : g_bad_data
      $error("data bus narrower than the clock-select field");
   end
   if (DIV_W < MAX_SHIFT) begin : g_bad_div
      $error("divider too short for the largest ratio");
   end
   if (ADDR_W < 7) begin : g_bad_addr
      $error("address bus cannot reach the register map");
   end

   logic [CS_W-1:0]  cs_w;
   logic             tick_w;
   logic             ie_w;
   logic             cnt_wr_w;
   logic [CNT_W-1:0] cnt_wdata_w;
   logic [CNT_W-1:0] cnt_w;
   logic             ovf_w;
   logic             flag_w;
   logic             sw_clr_w;

   ovf_timer_prescale #(.DIV_W(DIV_W)) u_pre (
      .clk  (clk),
      .rst_n(rst_n),
      .cs   (cs_w),
      .tick (tick_w)
   );

   ovf_timer_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_addr   (bus_addr),
      .bus_we     (bus_we),
      .bus_wdata  (bus_wdata),
      .bus_rdata  (bus_rdata),
      .cnt_val    (cnt_w),
      .flag_val   (flag_w),
      .cs         (cs_w),
      .ovf_ie     (ie_w),
      .cnt_wr     (cnt_wr_w),
      .cnt_wdata  (cnt_wdata_w),
      .flag_wr_clr(sw_clr_w)
   );

   ovf_timer_count #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick_w),
      .cnt_wr   (cnt_wr_w),
      .cnt_wdata(cnt_wdata_w),
      .cnt_q    (cnt_w),
      .ovf_evt  (ovf_w)
   );

   ovf_timer_irq #(.ENTRY_CYCLES(ENTRY_CYCLES), .VEC_W(VEC_W), .VEC_ADDR(VEC_ADDR)) u_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .ovf_evt  (ovf_w),
      .sw_clr   (sw_clr_w),
      .ovf_ie   (ie_w),
      .glob_ie  (glob_ie),
      .irq_ack  (irq_ack),
      .flag_q   (flag_w),
      .irq_req  (irq_req),
      .vec_valid(vec_valid),
      .vec_addr (vec_addr)
   );

endmodule

// File: rtl/ovf_timer_chk.sv
module ovf_timer_chk #(
   parameter int unsigned CNT_W    = 8,
   parameter int unsigned VEC_W    = 16,
   parameter int unsigned VEC_ADDR = 32'h20
)(
   input logic             clk,
   input logic             rst_n,
   input logic [2:0]       cs,
   input logic             tick,
   input logic [CNT_W-1:0] cnt,
   input logic             cnt_wr,
   input logic [CNT_W-1:0] cnt_wdata,
   input logic             flag,
   input logic             ie,
   input logic             gie,
   input logic             ovf,
   input logic             irq_req,
   input logic             irq_ack,
   input logic             vec_valid,
   input logic [VEC_W-1:0] vec_addr
);

   p_step_each_clock_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (cs == 3'd1 && !cnt_wr) |=> cnt == CNT_W'($past(cnt) + 1'b1));

   p_hold_when_stopped_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ((cs == 3'd0 || cs == 3'd6 || cs == 3'd7) && !cnt_wr) |=> $stable(cnt));

   p_wrap_sets_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && (&cnt) && !cnt_wr) |=> (cnt == '0 && flag));

   p_request_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> (flag && ie && gie));

   p_accept_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_req && irq_ack && !ovf) |=> !flag);

   p_vector_value_r7: assert property (@(posedge clk) disable iff (!rst_n)
      vec_valid |-> (vec_addr == VEC_W'(VEC_ADDR) && !irq_req));

   p_write_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_wr |=> (cnt == $past(cnt_wdata) && (!flag || $past(flag))));

endmodule

bind ovf_timer ovf_timer_chk #(.CNT_W(CNT_W), .VEC_W(VEC_W), .VEC_ADDR(VEC_ADDR)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cs       (cs_w),
   .tick     (tick_w),
   .cnt      (cnt_w),
   .cnt_wr   (cnt_wr_w),
   .cnt_wdata(cnt_wdata_w),
   .flag     (flag_w),
   .ie       (ie_w),
   .gie      (glob_ie),
   .ovf      (ovf_w),
   .irq_req  (irq_req),
   .irq_ack  (irq_ack),
   .vec_valid(vec_valid),
   .vec_addr (vec_addr)
);

// File: tb/ovf_timer_test.sv
module ovf_timer_test;

   localparam int CLK_PERIOD = 10;
   localparam logic [7:0] A_CTRL = 8'h45;
   localparam logic [7:0] A_CNT  = 8'h46;
   localparam logic [7:0] A_FLAG = 8'h35;
   localparam logic [7:0] A_MASK = 8'h6E;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = 8'h00;
   logic        bus_we = 1'b0;
   logic [7:0]  bus_wdata = 8'h00;
   logic [7:0]  bus_rdata;
   logic        glob_ie = 1'b0;
   logic        irq_req;
   logic        irq_ack = 1'b0;
   logic        vec_valid;
   logic [15:0] vec_addr;

   int nchk = 0;
   int nerr = 0;
   int ncyc = 0;

   ovf_timer uut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .glob_ie(glob_ie),
      .irq_req(irq_req), .irq_ack(irq_ack), .vec_valid(vec_valid), .vec_addr(vec_addr)
   );

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) if (rst_n) ncyc <= ncyc + 1;

   function automatic int ratio_shift(input int sel);
      case (sel)
         1: return 0;
         2: return 3;
         3: return 6;
         4: return 8;
         5: return 10;
         default: return -1;
      endcase
   endfunction

   // ticks on edges a .. m-1, tick on edge n when n mod 2^sh == 2^sh-1
   function automatic int ticks_between(input int sel, input int a, input int m);
      int sh = ratio_shift(sel);
      if (sh < 0) return 0;
      return (m >> sh) - (a >> sh);
   endfunction

   task automatic check(input string req, input int act, input int exp);
      nchk++;
      if (act != exp) begin
         nerr++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic bus_wr(input logic [7:0] a, input logic [7:0] d);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(posedge clk);
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output int d);
      bus_addr = a;
      #1;
      d = int'(bus_rdata);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      nerr++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

   initial begin
      int v;
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // reset state
      rd(A_CNT, v);  check("R8 reset counter", v, 0);
      rd(A_FLAG, v); check("R4 reset flag", v, 0);
      rd(A_CTRL, v); check("R8 reset ctrl", v, 0);
      check("R5 reset request", int'(irq_req), 0);

      // R2 phase: select 3 written on edge 0, first tick on edge 63
      bus_wr(A_CTRL, 8'd3);
      while (ncyc < 63) @(negedge clk);
      rd(A_CNT, v); check("R2 before first /64 tick", v, 0);
      @(negedge clk);
      rd(A_CNT, v); check("R2 first /64 tick", v, 1);

      // R1 directed step
      bus_wr(A_CTRL, 8'd0);
      bus_wr(A_CNT, 8'hFE);
      bus_wr(A_CTRL, 8'd1);
      rd(A_CNT, v); check("R1 no step on select write edge", v, 8'hFE);
      @(negedge clk);
      rd(A_CNT, v); check("R1 single step", v, 8'hFF);
      @(negedge clk);
      rd(A_CNT, v); check("R4 wrap to zero", v, 0);
      rd(A_FLAG, v); check("R4 overflow flag", v, 1);

      // random ratio trials
      for (int t = 0; t < 40; t++) begin
         int sel, start, w, a, tk, hi;
         sel = int'($urandom_range(0, 7));
         start = int'($urandom_range(0, 255));
         w = (t % 10 == 9) ? 2100 : int'($urandom_range(0, 700));
         hi = int'($urandom_range(0, 31));
         bus_wr(A_CTRL, 8'd0);
         bus_wr(A_FLAG, 8'h01);
         bus_wr(A_CNT, 8'(start));
         a = ncyc + 1;
         bus_wr(A_CTRL, 8'((hi << 3) | sel));
         rd(A_CTRL, v); check("R8 ctrl keeps low bits", v, sel);
         repeat (w) @(negedge clk);
         tk = ticks_between(sel, a, ncyc);
         rd(A_CNT, v);
         if (sel == 1)      check("R1 random count", v, (start + tk) % 256);
         else if (tk == 0 && ratio_shift(sel) < 0)
                            check("R3 stopped count", v, start);
         else               check("R2 random count", v, (start + tk) % 256);
         rd(A_FLAG, v); check("R4 random flag", v, (start + tk >= 256) ? 1 : 0);
      end

      // interrupt gating
      bus_wr(A_CTRL, 8'd0);
      bus_wr(A_FLAG, 8'h01);
      bus_wr(A_MASK, 8'hFF);
      rd(A_MASK, v); check("R8 mask keeps bit 0", v, 1);
      glob_ie = 1'b0;
      bus_wr(A_CNT, 8'hFF);
      bus_wr(A_CTRL, 8'd1);
      @(negedge clk);
      bus_wr(A_CTRL, 8'd0);
      rd(A_FLAG, v); check("R4 flag after wrap", v, 1);
      check("R5 no request with global off", int'(irq_req), 0);
      irq_ack = 1'b1;
      @(negedge clk);
      irq_ack = 1'b0;
      rd(A_FLAG, v); check("R5 ack ignored without request", v, 1);
      glob_ie = 1'b1;
      #1 check("R5 request when all set", int'(irq_req), 1);
      bus_wr(A_MASK, 8'h00);
      check("R5 no request with enable off", int'(irq_req), 0);
      rd(A_FLAG, v); check("R5 flag held", v, 1);
      bus_wr(A_MASK, 8'h01);
      check("R5 request restored", int'(irq_req), 1);
      irq_ack = 1'b1;
      @(posedge clk);
      @(negedge clk);
      irq_ack = 1'b0;
      rd(A_FLAG, v); check("R6 accept clears flag", v, 0);
      check("R7 first entry cycle", int'(vec_valid), 0);
      @(negedge clk);
      check("R7 vector valid", int'(vec_valid), 1);
      check("R7 vector address", int'(vec_addr), 32'h20);
      @(negedge clk);
      check("R7 vector one cycle", int'(vec_valid), 0);
      glob_ie = 1'b0;

      // software clear
      bus_wr(A_CNT, 8'hFF);
      bus_wr(A_CTRL, 8'd1);
      bus_wr(A_FLAG, 8'h01);
      bus_wr(A_CTRL, 8'd0);
      rd(A_FLAG, v); check("R9 overflow beats clear", v, 1);
      bus_wr(A_FLAG, 8'h00);
      rd(A_FLAG, v); check("R9 write 0 no effect", v, 1);
      bus_wr(A_FLAG, 8'hFE);
      rd(A_FLAG, v); check("R9 bit0 zero no effect", v, 1);
      bus_wr(A_FLAG, 8'h01);
      rd(A_FLAG, v); check("R9 write 1 clears", v, 0);

      // write priority
      bus_wr(A_CTRL, 8'd1);
      bus_wr(A_CNT, 8'h10);
      rd(A_CNT, v); check("R10 write beats tick", v, 8'h10);
      @(negedge clk);
      rd(A_CNT, v); check("R1 step after write", v, 8'h11);
      bus_wr(A_CNT, 8'hFF);
      bus_wr(A_CNT, 8'h05);
      rd(A_CNT, v); check("R10 write at 0xFF", v, 8'h05);
      rd(A_FLAG, v); check("R10 no overflow on write", v, 0);
      bus_wr(A_CTRL, 8'd0);
      rd(8'h00, v); check("R8 unmapped read", v, 0);

      $display("  Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

endmodule